// File: doc/BRIEF.md
# Core Select Register and Parallel Test Router

This block sits at chip level between one parallel test port and a row of wrapped cores. A serially loaded select register holds a small group of bits for each core and marks which cores take part in the current test session. A core whose group holds any 1 is selected. A core whose group is all zero is left isolated, with its control and data inputs held at zero.

The register has two stages. A shift stage is loaded one bit per clock while the shift enable is high. An update strobe then copies the shift stage into the active selection. Routing follows only the active selection, so a new selection can be shifted in between tests without disturbing the test that is running.

A two-bit mode input chooses how the parallel port reaches the selected cores. In multiplexed mode one core at a time owns the shared port. In chained mode data passes through the selected cores in index order. In direct mode each core uses its own dedicated pins. A fourth mode value isolates every core.

Top module: `core_sel_router`

## Requirements
- R1: After reset the active selection (`sel_bits_o`) is all zero, `core_en_o` is zero, `mux_err_o` is 0 and `tp_do_o` is zero.
- R2: `sh_do_o` always shows bit 0 of the shift stage. Each clock with `sh_en_i` high moves the shift stage one place toward bit 0 and places `sh_di_i` in the top bit. Bits therefore come out of `sh_do_o` in the order they went in, after a delay of N_CORES*BITS_PER_CORE shifts.
- R3: Shifting alone never changes `sel_bits_o` or the routing. A clock with `upd_i` high copies the shift stage into `sel_bits_o`, and the new value appears at that edge. When `upd_i` and `sh_en_i` are high in the same clock, the value copied is the shift stage as it stood before that shift.
- R4: Core k owns bits [k*BITS_PER_CORE +: BITS_PER_CORE] of the selection. It is selected when any of those bits is 1.
- R5: In mode 0 (multiplexed), only the lowest-index selected core is connected. It receives `tp_ctl_i` and `tp_di_i`, and `tp_do_o` carries its `core_do_i` slice. `core_en_o` is one-hot for that core. With no core selected, `tp_do_o` is zero.
- R6: `mux_err_o` is 1 exactly when the mode is 0 and more than one core is selected.
- R7: In mode 1 (chained), every selected core receives `tp_ctl_i`. Core 0 is fed from `tp_di_i`, each later core is fed from the link before it, and `tp_do_o` is the last link. A selected core passes its `core_do_i` on to the next link. A deselected core passes the data it was fed through exactly one register stage.
- R8: In mode 2 (direct), each selected core k receives `dir_ctl_i` slice k and `dir_di_i` slice k, and `dir_do_o` slice k equals its `core_do_i` slice k. In every other mode, `dir_do_o` is zero.
- R9: In mode 3, no core is enabled, and `tp_do_o` and `dir_do_o` are zero.
- R10: In every mode, a core that is not connected receives zero on `core_ctl_o` and `core_di_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sh_en_i | input | 1 | Shift enable for the select register |
| sh_di_i | input | 1 | Serial data into the select register |
| upd_i | input | 1 | Update strobe: copies the shift stage into the active selection |
| sh_do_o | output | 1 | Serial data out of the select register (bit 0 of the shift stage) |
| mode_i | input | 2 | Routing mode: 0 multiplexed, 1 chained, 2 direct, 3 all isolated |
| tp_ctl_i | input | CTL_W | Shared parallel control |
| tp_di_i | input | DAT_W | Shared parallel data in |
| tp_do_o | output | DAT_W | Shared parallel data out |
| dir_ctl_i | input | N_CORES*CTL_W | Per-core control used in direct mode |
| dir_di_i | input | N_CORES*DAT_W | Per-core data in used in direct mode |
| dir_do_o | output | N_CORES*DAT_W | Per-core data out used in direct mode |
| core_ctl_o | output | N_CORES*CTL_W | Control to each core's parallel port |
| core_di_o | output | N_CORES*DAT_W | Data to each core's parallel input |
| core_do_i | input | N_CORES*DAT_W | Data from each core's parallel output |
| core_en_o | output | N_CORES | Core is connected in the current mode |
| sel_bits_o | output | N_CORES*BITS_PER_CORE | Active selection, including the finer per-core bits |
| mux_err_o | output | 1 | More than one core is selected in multiplexed mode |

## Verification
The shift path and the update strobe can act in the same clock. The test provokes this by first shifting a pattern into the shift stage that differs from the active selection. It then raises `upd_i` and `sh_en_i` together, with a 1 on the serial input. The result is judged correct only if `sel_bits_o` takes the pre-shift pattern, not the shifted one. In the same way, a chained-mode run with a deselected middle core checks that the bypass stage delays data by exactly one clock while the selected neighbours pass data straight through.

// File: rtl/core_sel_pkg.sv
package core_sel_pkg;

    typedef enum logic [1:0] {
        RT_MUX    = 2'd0,
        RT_CHAIN  = 2'd1,
        RT_DIRECT = 2'd2,
        RT_OFF    = 2'd3
    } route_mode_e;

endpackage

// File: rtl/sel_chain.sv
module sel_chain #(
    parameter int W = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         sh_en_i,
    input  logic         sh_di_i,
    input  logic         upd_i,
    output logic         sh_do_o,
    output logic [W-1:0] sel_o
);

    typedef struct packed {
        logic [W-1:0] shf;
        logic [W-1:0] act;
    } chain_st_t;

    chain_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // the update takes the shift stage as it was before this edge
        if (upd_i) begin
            st_d.act = st_q.shf;
        end
        if (sh_en_i) begin
            if (W > 1) begin
                st_d.shf = {sh_di_i, st_q.shf[W-1:1]};
            end else begin
                st_d.shf[W-1] = sh_di_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_do_o = st_q.shf[0];
    assign sel_o   = st_q.act;

endmodule

// File: rtl/chain_bypass.sv
module chain_bypass #(
    parameter int N  = 3,
    parameter int DW = 8
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [DW-1:0]   head_i,
    input  logic [N-1:0]    sel_i,
    input  logic [N*DW-1:0] core_do_i,
    output logic [N*DW-1:0] link_o,
    output logic [DW-1:0]   tail_o
);

    typedef struct packed {
        logic [N*DW-1:0] byp;
    } byp_st_t;

    byp_st_t st_d, st_q;
    logic [DW-1:0] link [N+1];

    always_comb begin
        st_d    = st_q;
        link[0] = head_i;
        link_o  = '0;
        for (int k = 0; k < N; k++) begin
            link_o[k*DW +: DW] = link[k];
            st_d.byp[k*DW +: DW] = link[k];
            if (sel_i[k]) begin
                link[k+1] = core_do_i[k*DW +: DW];
            end else begin
                link[k+1] = st_q.byp[k*DW +: DW];
            end
        end
        tail_o = link[N];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/port_router.sv
module port_router
    import core_sel_pkg::*;
#(
    parameter int N  = 3,
    parameter int CW = 2,
    parameter int DW = 8
) (
    input  logic [1:0]      mode_i,
    input  logic [N-1:0]    sel_i,
    input  logic [CW-1:0]   tp_ctl_i,
    input  logic [DW-1:0]   tp_di_i,
    input  logic [N*CW-1:0] dir_ctl_i,
    input  logic [N*DW-1:0] dir_di_i,
    input  logic [N*DW-1:0] core_do_i,
    input  logic [N*DW-1:0] link_i,
    input  logic [DW-1:0]   tail_i,
    output logic [DW-1:0]   tp_do_o,
    output logic [N*DW-1:0] dir_do_o,
    output logic [N*CW-1:0] core_ctl_o,
    output logic [N*DW-1:0] core_di_o,
    output logic [N-1:0]    core_en_o,
    output logic            mux_err_o
);

    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] pick;
    logic             found;
    logic             multi;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        multi = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (sel_i[k]) begin
                if (found) begin
                    multi = 1'b1;
                end else begin
                    pick  = IDX_W'(k);
                    found = 1'b1;
                end
            end
        end
    end

    always_comb begin
        tp_do_o    = '0;
        dir_do_o   = '0;
        core_ctl_o = '0;
        core_di_o  = '0;
        core_en_o  = '0;
        mux_err_o  = 1'b0;
        unique case (route_mode_e'(mode_i))
            RT_MUX: begin
                mux_err_o = multi;
                if (found) begin
                    core_en_o[pick]            = 1'b1;
                    core_ctl_o[pick*CW +: CW]  = tp_ctl_i;
                    core_di_o[pick*DW +: DW]   = tp_di_i;
                    tp_do_o                    = core_do_i[pick*DW +: DW];
                end
            end
            RT_CHAIN: begin
                tp_do_o = tail_i;
                for (int k = 0; k < N; k++) begin
                    if (sel_i[k]) begin
                        core_en_o[k]          = 1'b1;
                        core_ctl_o[k*CW +: CW] = tp_ctl_i;
                        core_di_o[k*DW +: DW]  = link_i[k*DW +: DW];
                    end
                end
            end
            RT_DIRECT: begin
                for (int k = 0; k < N; k++) begin
                    if (sel_i[k]) begin
                        core_en_o[k]           = 1'b1;
                        core_ctl_o[k*CW +: CW] = dir_ctl_i[k*CW +: CW];
                        core_di_o[k*DW +: DW]  = dir_di_i[k*DW +: DW];
                        dir_do_o[k*DW +: DW]   = core_do_i[k*DW +: DW];
                    end
                end
            end
            default: begin
                core_en_o = '0;
            end
        endcase
    end

endmodule

// File: rtl/core_sel_router.sv
module core_sel_router #(
    parameter int N_CORES       = 3,
    parameter int BITS_PER_CORE = 2,
    parameter int CTL_W         = 2,
    parameter int DAT_W         = 8
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       sh_en_i,
    input  logic                       sh_di_i,
    input  logic                       upd_i,
    output logic                       sh_do_o,
    input  logic [1:0]                 mode_i,
    input  logic [CTL_W-1:0]           tp_ctl_i,
    input  logic [DAT_W-1:0]           tp_di_i,
    output logic [DAT_W-1:0]           tp_do_o,
    input  logic [N_CORES*CTL_W-1:0]   dir_ctl_i,
    input  logic [N_CORES*DAT_W-1:0]   dir_di_i,
    output logic [N_CORES*DAT_W-1:0]   dir_do_o,
    output logic [N_CORES*CTL_W-1:0]   core_ctl_o,
    output logic [N_CORES*DAT_W-1:0]   core_di_o,
    input  logic [N_CORES*DAT_W-1:0]   core_do_i,
    output logic [N_CORES-1:0]         core_en_o,
    output logic [N_CORES*BITS_PER_CORE-1:0] sel_bits_o,
    output logic                       mux_err_o
);

    localparam int SEL_W = N_CORES * BITS_PER_CORE;

    logic [SEL_W-1:0]         sel_bits;
    logic [N_CORES-1:0]       core_sel;
    logic [N_CORES*DAT_W-1:0] link;
    logic [DAT_W-1:0]         tail;

    sel_chain #(.W(SEL_W)) u_chain (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .sh_en_i (sh_en_i),
        .sh_di_i (sh_di_i),
        .upd_i   (upd_i),
        .sh_do_o (sh_do_o),
        .sel_o   (sel_bits)
    );

    for (genvar g = 0; g < N_CORES; g++) begin : g_core_sel
        assign core_sel[g] = |sel_bits[g*BITS_PER_CORE +: BITS_PER_CORE];
    end

    chain_bypass #(.N(N_CORES), .DW(DAT_W)) u_byp (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .head_i    (tp_di_i),
        .sel_i     (core_sel),
        .core_do_i (core_do_i),
        .link_o    (link),
        .tail_o    (tail)
    );

    port_router #(.N(N_CORES), .CW(CTL_W), .DW(DAT_W)) u_route (
        .mode_i     (mode_i),
        .sel_i      (core_sel),
        .tp_ctl_i   (tp_ctl_i),
        .tp_di_i    (tp_di_i),
        .dir_ctl_i  (dir_ctl_i),
        .dir_di_i   (dir_di_i),
        .core_do_i  (core_do_i),
        .link_i     (link),
        .tail_i     (tail),
        .tp_do_o    (tp_do_o),
        .dir_do_o   (dir_do_o),
        .core_ctl_o (core_ctl_o),
        .core_di_o  (core_di_o),
        .core_en_o  (core_en_o),
        .mux_err_o  (mux_err_o)
    );

    assign sel_bits_o = sel_bits;

endmodule

// File: rtl/core_sel_router_chk.sv
module core_sel_router_chk #(
    parameter int N_CORES       = 3,
    parameter int BITS_PER_CORE = 2,
    parameter int DAT_W         = 8
) (
    input logic                               clk_i,
    input logic                               rst_ni,
    input logic                               sh_en_i,
    input logic                               upd_i,
    input logic                               sh_do_o,
    input logic [1:0]                         mode_i,
    input logic [DAT_W-1:0]                   tp_do_o,
    input logic [N_CORES*DAT_W-1:0]           dir_do_o,
    input logic [N_CORES-1:0]                 core_en_o,
    input logic [N_CORES*BITS_PER_CORE-1:0]   sel_bits_o,
    input logic                               mux_err_o
);

    a_r2_shift_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sh_en_i |=> $stable(sh_do_o));

    a_r3_no_update_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !upd_i |=> $stable(sel_bits_o));

    a_r3_update_copies_bit0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        upd_i |=> sel_bits_o[0] == $past(sh_do_o));

    a_r5_mux_one_core: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i == 2'd0 |-> $onehot0(core_en_o));

    a_r6_err_only_mux_multi: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mux_err_o |-> (mode_i == 2'd0) && ($countones(sel_bits_o) > 1));

    a_r8_dir_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i != 2'd2 |-> dir_do_o == '0);

    a_r9_off_isolates: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mode_i == 2'd3 |-> (core_en_o == '0) && (tp_do_o == '0));

endmodule

bind core_sel_router core_sel_router_chk #(
    .N_CORES       (N_CORES),
    .BITS_PER_CORE (BITS_PER_CORE),
    .DAT_W         (DAT_W)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sh_en_i    (sh_en_i),
    .upd_i      (upd_i),
    .sh_do_o    (sh_do_o),
    .mode_i     (mode_i),
    .tp_do_o    (tp_do_o),
    .dir_do_o   (dir_do_o),
    .core_en_o  (core_en_o),
    .sel_bits_o (sel_bits_o),
    .mux_err_o  (mux_err_o)
);

// File: tb/test_core_sel_router.sv
module test_core_sel_router;

    localparam int N   = 3;
    localparam int BPC = 2;
    localparam int CW  = 2;
    localparam int DW  = 8;
    localparam int SW  = N * BPC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sh_en = 1'b0, sh_di = 1'b0, upd = 1'b0, sh_do;
    logic [1:0] mode = 2'd0;
    logic [CW-1:0] tp_ctl = 2'b11;
    logic [DW-1:0] tp_di = 8'hA5, tp_do;
    logic [N*CW-1:0] dir_ctl = {2'b10, 2'b01, 2'b11};
    logic [N*DW-1:0] dir_di = {8'hC3, 8'hC2, 8'hC1}, dir_do;
    logic [N*CW-1:0] core_ctl;
    logic [N*DW-1:0] core_di;
    logic [N*DW-1:0] core_do = {8'h33, 8'h22, 8'h11};
    logic [N-1:0] core_en;
    logic [SW-1:0] sel_bits;
    logic mux_err;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    core_sel_router #(.N_CORES(N), .BITS_PER_CORE(BPC), .CTL_W(CW), .DAT_W(DW)) i_core_sel_router (
        .clk_i(clk), .rst_ni(rst_n), .sh_en_i(sh_en), .sh_di_i(sh_di), .upd_i(upd),
        .sh_do_o(sh_do), .mode_i(mode), .tp_ctl_i(tp_ctl), .tp_di_i(tp_di),
        .tp_do_o(tp_do), .dir_ctl_i(dir_ctl), .dir_di_i(dir_di), .dir_do_o(dir_do),
        .core_ctl_o(core_ctl), .core_di_o(core_di), .core_do_i(core_do),
        .core_en_o(core_en), .sel_bits_o(sel_bits), .mux_err_o(mux_err)
    );

    // {sel bits, mode, expected tp_do, expected err, expected core_en}
    localparam logic [19:0] VEC [8] = '{
        {6'b00_00_01, 2'd0, 8'h11, 1'b0, 3'b001},
        {6'b01_10_00, 2'd0, 8'h22, 1'b1, 3'b010},
        {6'b11_00_00, 2'd0, 8'h33, 1'b0, 3'b100},
        {6'b00_00_00, 2'd0, 8'h00, 1'b0, 3'b000},
        {6'b10_01_01, 2'd2, 8'h00, 1'b0, 3'b111},
        {6'b10_01_01, 2'd3, 8'h00, 1'b0, 3'b000},
        {6'b10_01_01, 2'd1, 8'h33, 1'b0, 3'b111},
        {6'b11_10_01, 2'd0, 8'h11, 1'b1, 3'b001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic shift_in(input logic [SW-1:0] pat);
        for (int i = 0; i < SW; i++) begin
            sh_en = 1'b1;
            sh_di = pat[i];
            step();
        end
        sh_en = 1'b0;
        sh_di = 1'b0;
    endtask

    task automatic load(input logic [SW-1:0] pat);
        shift_in(pat);
        upd = 1'b1;
        step();
        upd = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step();
        step();
        // R1: reset state
        check("R1 sel", 32'(sel_bits), 32'h0);
        check("R1 en", 32'(core_en), 32'h0);
        check("R1 err", 32'(mux_err), 32'h0);
        check("R1 tp_do", 32'(tp_do), 32'h0);
        rst_n = 1'b1;
        step();

        // table walk: R4 R5 R6 R7 R8 R9 R10
        for (int v = 0; v < 8; v++) begin
            logic [SW-1:0] s;
            logic [1:0] m;
            s = VEC[v][19:14];
            m = VEC[v][13:12];
            mode = m;
            load(s);
            check("R3 R4 sel", 32'(sel_bits), 32'(s));
            check("R5 R7 R8 R9 tp_do", 32'(tp_do), 32'(VEC[v][11:4]));
            check("R6 err", 32'(mux_err), 32'(VEC[v][3]));
            check("R4 en", 32'(core_en), 32'(VEC[v][2:0]));
            for (int k = 0; k < N; k++) begin
                logic [DW-1:0] edi;
                logic [CW-1:0] ect;
                logic [DW-1:0] edo;
                edi = '0; ect = '0; edo = '0;
                if (VEC[v][k]) begin
                    if (m == 2'd2) begin
                        edi = dir_di[k*DW +: DW];
                        ect = dir_ctl[k*CW +: CW];
                        edo = core_do[k*DW +: DW];
                    end else if (m == 2'd0 || k == 0) begin
                        edi = tp_di;
                        ect = tp_ctl;
                    end else begin
                        edi = core_do[(k-1)*DW +: DW];
                        ect = tp_ctl;
                    end
                end
                check("R10 R8 core di", 32'(core_di[k*DW +: DW]), 32'(edi));
                check("R10 R8 core ctl", 32'(core_ctl[k*CW +: CW]), 32'(ect));
                check("R8 dir_do", 32'(dir_do[k*DW +: DW]), 32'(edo));
            end
        end

        // R3: shifting alone leaves routing alone; update applies at its edge
        mode = 2'd0;
        load(6'b00_00_11);
        shift_in(6'b10_10_00);
        check("R3 hold sel", 32'(sel_bits), 32'h03);
        check("R3 hold tp_do", 32'(tp_do), 32'h11);
        // R3: shift and update in the same clock take the pre-shift stage
        sh_en = 1'b1; sh_di = 1'b1; upd = 1'b1;
        step();
        sh_en = 1'b0; sh_di = 1'b0; upd = 1'b0;
        check("R3 same-cycle sel", 32'(sel_bits), 32'b10_10_00);
        check("R2 shifted bit0", 32'(sh_do), 32'h0);

        // R2: serial out order
        shift_in(6'b01_10_11);
        for (int i = 0; i < SW; i++) begin
            check("R2 shift out", 32'(sh_do), 32'((6'b01_10_11 >> i) & 1));
            sh_en = 1'b1;
            step();
        end
        sh_en = 1'b0;

        // R7: deselected middle core adds one register stage
        mode = 2'd1;
        load(6'b01_00_01);
        core_do[7:0] = 8'h5A;
        step();
        check("R7 bypass delay", 32'(core_di[2*DW +: DW]), 32'h5A);
        check("R7 tail", 32'(tp_do), 32'h33);
        check("R10 chain isolated", 32'(core_di[DW +: DW]), 32'h0);
        core_do[7:0] = 8'h77;
        #1;
        check("R7 not yet", 32'(core_di[2*DW +: DW]), 32'h5A);
        step();
        check("R7 next", 32'(core_di[2*DW +: DW]), 32'h77);

        // R8: dir_do quiet outside direct mode
        mode = 2'd0;
        load(6'b11_11_11);
        check("R8 dir quiet", 32'(dir_do), 32'h0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule